// File: doc/BRIEF.md
# Paged Bus Address Decoder

This block sits between an 8-bit CPU's 16-bit address bus and a 20-bit system bus. On each edge of the system clock it samples the CPU address, the read/write line, the phase 2 clock and the state of the bank and memory control registers. It then registers a set of chip selects for RAM, the OS ROM, the I/O register page and six expansion slots, together with the four upper address lines that reach the memories.

The lowest 4 KiB is pinned to RAM bank 0. Three 4 KiB windows above it stay in bank 0 unless a control bit lets each one follow the bank register. The large middle region and the RAM above the I/O page always follow the bank register. In that case banks 0–7 are RAM, banks 8–13 are the six logical expansion slots and banks 14–15 are ROM pages. The top 12 KiB is the OS ROM. It can be replaced by bank 0 RAM for all accesses, or only writes can be steered into the RAM beneath it.

Top module: `paged_bus_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every select output is low after that edge and `bank_addr` is 0.
- R2: When `phi2` was low at the sampling edge, no select is active after it, but `bank_addr` still carries the resolved bank.
- R3: Addresses 0x0000–0x0FFF select RAM with `bank_addr` = 0, whatever `bank_reg` holds.
- R4: The windows 0x1000–0x1FFF, 0x2000–0x2FFF and 0x3000–0x3FFF are controlled by `page_en` bits 0, 1 and 2. When the bit is clear the window selects RAM with `bank_addr` = 0. When the bit is set the window follows `bank_reg` as in R5.
- R5: For 0x4000–0xBFFF and 0xC100–0xCFFF, `bank_addr` = `bank_reg`. Banks 0–7 select RAM. Bank 8+n (n = 0..5) sets `slot_cs[n]`. Banks 14–15 select ROM.
- R6: Addresses 0xC000–0xC0FF assert `io_cs` with `bank_addr` = 0, whatever `bank_reg` holds. `io_grp_sel` is one-hot, with bit k set where k is address bits 7:4. `io_grp_sel` is all zero whenever `io_cs` is low.
- R7: In 0xD000–0xFFFF with `rom_shadow` = 0, reads select ROM with `bank_addr` = 0. With `rom_shadow` = 1, reads and writes select RAM with `bank_addr` = 0.
- R8: A write to 0xD000–0xFFFF with `rom_shadow` = 0 selects RAM bank 0 when `rom_wr_under` = 1 and selects nothing when it is 0. `rom_wr_under` does not change reads.
- R9: At most one of `ram_cs`, `rom_cs`, `io_cs` and the `slot_cs` bits is high in any cycle.
- R10: Outputs change one clock after the inputs they reflect and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | CPU phase 2 clock level |
| bank_reg | input | 4 | Current bank register value |
| page_en | input | 3 | Per-window paging enable for the three windows above 0x1000 |
| rom_shadow | input | 1 | Replace the ROM region with bank 0 RAM |
| rom_wr_under | input | 1 | Steer writes in the ROM region to bank 0 RAM |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | ROM select |
| io_cs | output | 1 | I/O register page select |
| slot_cs | output | 6 | One select per logical expansion slot |
| io_grp_sel | output | 16 | One-hot 16-byte register group inside the I/O page |
| bank_addr | output | 4 | Upper address lines A16–A19 |

## Verification
A vector table walks the region edges: the first and last byte of each window, the I/O page against the banked RAM next to it, and the ROM boundary. It also walks the bank register across its three classes: RAM at banks 0 and 7, slots at 8 and 13, and ROM at 14 and 15. Paired vectors change only one paging bit, the read/write line, or one of the two ROM controls, so a swapped window bit or a mixed-up shadow and write-under path shows up as a wrong select. Directed tests sweep all sixteen I/O groups, hold reset against an address that would select memory, and probe between edges to show the one-cycle delay.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int BANK_W       = 4;
    localparam int NUM_PAGE_WIN = 3;

    typedef enum logic [2:0] {
        RG_LOW_FIXED,
        RG_PAGE_WIN,
        RG_BANKED,
        RG_IO,
        RG_ROM
    } region_e;

    typedef enum logic [2:0] {
        TG_NONE,
        TG_RAM,
        TG_ROM,
        TG_IO,
        TG_SLOT
    } target_e;

    typedef struct packed {
        logic [NUM_PAGE_WIN-1:0] page_en;
        logic                    shadow;
        logic                    wr_under;
    } memctl_t;

    typedef struct packed {
        target_e           kind;
        logic [BANK_W-1:0] bank;
    } route_t;

    localparam route_t ROUTE_NONE = '{kind: TG_NONE, bank: '0};
    localparam route_t ROUTE_RAM0 = '{kind: TG_RAM,  bank: '0};

    // Map a bank number onto the kind of device that owns it.
    function automatic route_t route_bank(input logic [BANK_W-1:0] bank,
                                          input int num_ram,
                                          input int slot_base,
                                          input int num_slots);
        route_t r;
        r.bank = bank;
        if (int'(bank) < num_ram)
            r.kind = TG_RAM;
        else if (int'(bank) >= slot_base && int'(bank) < slot_base + num_slots)
            r.kind = TG_SLOT;
        else
            r.kind = TG_ROM;
        return r;
    endfunction

endpackage

// File: rtl/pbd_region.sv
module pbd_region
    import pbd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [1:0]        win_idx
);
    localparam int TOP_LO = ADDR_W - 4;
    localparam int MID_LO = ADDR_W - 8;
    localparam logic [3:0] IO_TOP   = 4'hC;
    localparam logic [3:0] LAST_WIN = 4'(NUM_PAGE_WIN);

    logic [3:0] top_nib;
    logic [3:0] mid_nib;

    assign top_nib = addr[ADDR_W-1:TOP_LO];
    assign mid_nib = addr[TOP_LO-1:MID_LO];

    always_comb begin
        win_idx = '0;
        if (top_nib == 4'h0) begin
            region = RG_LOW_FIXED;
        end else if (top_nib <= LAST_WIN) begin
            region  = RG_PAGE_WIN;
            win_idx = 2'(top_nib - 4'd1);
        end else if (top_nib < IO_TOP) begin
            region = RG_BANKED;
        end else if (top_nib == IO_TOP) begin
            region = (mid_nib == 4'h0) ? RG_IO : RG_BANKED;
        end else begin
            region = RG_ROM;
        end
    end

endmodule

// File: rtl/pbd_route.sv
module pbd_route
    import pbd_pkg::*;
#(
    parameter int NUM_RAM_BANKS = 8,
    parameter int SLOT_BASE     = 8,
    parameter int NUM_SLOTS     = 6
) (
    input  region_e           region,
    input  logic [1:0]        win_idx,
    input  logic [BANK_W-1:0] bank,
    input  memctl_t           ctl,
    input  logic              rnw,
    output route_t            route
);
    logic win_follows;
    logic [NUM_PAGE_WIN-1:0] win_mask;

    assign win_mask    = NUM_PAGE_WIN'(1) << win_idx;
    assign win_follows = |(ctl.page_en & win_mask);

    always_comb begin
        route = ROUTE_NONE;
        unique case (region)
            RG_LOW_FIXED: route = ROUTE_RAM0;
            RG_PAGE_WIN: begin
                if (win_follows)
                    route = route_bank(bank, NUM_RAM_BANKS, SLOT_BASE, NUM_SLOTS);
                else
                    route = ROUTE_RAM0;
            end
            RG_BANKED: route = route_bank(bank, NUM_RAM_BANKS, SLOT_BASE, NUM_SLOTS);
            RG_IO:     route = '{kind: TG_IO, bank: '0};
            RG_ROM: begin
                if (ctl.shadow)
                    route = ROUTE_RAM0;
                else if (rnw)
                    route = '{kind: TG_ROM, bank: '0};
                else if (ctl.wr_under)
                    route = ROUTE_RAM0;
                else
                    route = ROUTE_NONE;
            end
            default: route = ROUTE_NONE;
        endcase
    end

endmodule

// File: rtl/pbd_select.sv
module pbd_select
    import pbd_pkg::*;
#(
    parameter int SLOT_BASE = 8,
    parameter int NUM_SLOTS = 6,
    parameter int GRP_W     = 4,
    localparam int GRP_N    = 1 << GRP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  route_t               route,
    input  logic                 phi2,
    input  logic [GRP_W-1:0]     grp,
    output logic                 ram_cs,
    output logic                 rom_cs,
    output logic                 io_cs,
    output logic [NUM_SLOTS-1:0] slot_cs,
    output logic [GRP_N-1:0]     io_grp_sel,
    output logic [BANK_W-1:0]    bank_addr
);
    logic                 ram_d, rom_d, io_d;
    logic [NUM_SLOTS-1:0] slot_d;
    logic [GRP_N-1:0]     grp_d;

    assign ram_d = phi2 && (route.kind == TG_RAM);
    assign rom_d = phi2 && (route.kind == TG_ROM);
    assign io_d  = phi2 && (route.kind == TG_IO);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [BANK_W-1:0] SLOT_BANK = BANK_W'(SLOT_BASE + s);
        assign slot_d[s] = phi2 && (route.kind == TG_SLOT) && (route.bank == SLOT_BANK);
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        assign grp_d[g] = io_d && (grp == GRP_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_cs     <= 1'b0;
            rom_cs     <= 1'b0;
            io_cs      <= 1'b0;
            slot_cs    <= '0;
            io_grp_sel <= '0;
            bank_addr  <= '0;
        end else begin
            ram_cs     <= ram_d;
            rom_cs     <= rom_d;
            io_cs      <= io_d;
            slot_cs    <= slot_d;
            io_grp_sel <= grp_d;
            bank_addr  <= route.bank;
        end
    end

endmodule

// File: rtl/paged_bus_decoder.sv
module paged_bus_decoder
    import pbd_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int NUM_RAM_BANKS = 8,
    parameter int SLOT_BASE     = 8,
    parameter int NUM_SLOTS     = 6,
    parameter int GRP_W         = 4,
    localparam int GRP_N        = 1 << GRP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    cpu_rnw,
    input  logic                    phi2,
    input  logic [BANK_W-1:0]       bank_reg,
    input  logic [NUM_PAGE_WIN-1:0] page_en,
    input  logic                    rom_shadow,
    input  logic                    rom_wr_under,
    output logic                    ram_cs,
    output logic                    rom_cs,
    output logic                    io_cs,
    output logic [NUM_SLOTS-1:0]    slot_cs,
    output logic [GRP_N-1:0]        io_grp_sel,
    output logic [BANK_W-1:0]       bank_addr
);
    region_e    region;
    logic [1:0] win_idx;
    memctl_t    ctl;
    route_t     route;

    assign ctl = '{page_en: page_en, shadow: rom_shadow, wr_under: rom_wr_under};

    pbd_region #(.ADDR_W(ADDR_W)) u_region (
        .addr    (cpu_addr),
        .region  (region),
        .win_idx (win_idx)
    );

    pbd_route #(
        .NUM_RAM_BANKS (NUM_RAM_BANKS),
        .SLOT_BASE     (SLOT_BASE),
        .NUM_SLOTS     (NUM_SLOTS)
    ) u_route (
        .region  (region),
        .win_idx (win_idx),
        .bank    (bank_reg),
        .ctl     (ctl),
        .rnw     (cpu_rnw),
        .route   (route)
    );

    pbd_select #(
        .SLOT_BASE (SLOT_BASE),
        .NUM_SLOTS (NUM_SLOTS),
        .GRP_W     (GRP_W)
    ) u_select (
        .clk        (clk),
        .rst        (rst),
        .route      (route),
        .phi2       (phi2),
        .grp        (cpu_addr[GRP_W+3:4]),
        .ram_cs     (ram_cs),
        .rom_cs     (rom_cs),
        .io_cs      (io_cs),
        .slot_cs    (slot_cs),
        .io_grp_sel (io_grp_sel),
        .bank_addr  (bank_addr)
    );

endmodule

// File: rtl/pbd_checker.sv
module pbd_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_rnw,
    input logic        phi2,
    input logic [3:0]  bank_reg,
    input logic [2:0]  page_en,
    input logic        rom_shadow,
    input logic        rom_wr_under,
    input logic        ram_cs,
    input logic        rom_cs,
    input logic        io_cs,
    input logic [5:0]  slot_cs,
    input logic [15:0] io_grp_sel,
    input logic [3:0]  bank_addr
);
    logic primed;
    logic any_cs;
    logic in_rom, in_io, win_closed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    assign any_cs = ram_cs | rom_cs | io_cs | (|slot_cs);
    assign in_rom = cpu_addr[15:12] >= 4'hD;
    assign in_io  = cpu_addr[15:8] == 8'hC0;

    always_comb begin
        case (cpu_addr[15:12])
            4'h1:    win_closed = !page_en[0];
            4'h2:    win_closed = !page_en[1];
            4'h3:    win_closed = !page_en[2];
            default: win_closed = 1'b0;
        endcase
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!any_cs && io_grp_sel == '0 && bank_addr == '0));

    p_phi2_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (primed && !$past(phi2)) |-> !any_cs);

    p_low_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(phi2) && $past(cpu_addr[15:12]) == 4'h0)
        |-> (ram_cs && bank_addr == 4'h0));

    p_window_closed_r4: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(phi2) && $past(win_closed))
        |-> (ram_cs && bank_addr == 4'h0));

    p_io_group_r6: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(phi2) && $past(in_io))
        |-> (io_cs && io_grp_sel == (16'd1 << $past(cpu_addr[7:4])) && bank_addr == 4'h0));

    p_grp_needs_io_r6: assert property (@(posedge clk) disable iff (rst)
        !io_cs |-> (io_grp_sel == '0));

    p_rom_read_r7: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(phi2) && $past(in_rom) && $past(cpu_rnw) && !$past(rom_shadow))
        |-> (rom_cs && bank_addr == 4'h0));

    p_wr_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(in_rom) && !$past(cpu_rnw) && !$past(rom_shadow) && !$past(rom_wr_under))
        |-> !any_cs);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_cs, rom_cs, io_cs, slot_cs}));

endmodule

bind paged_bus_decoder pbd_checker u_chk (.*);

// File: tb/paged_bus_decoder_test.sv
module paged_bus_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic        phi2 = 1'b0;
    logic [3:0]  bank_reg = '0;
    logic [2:0]  page_en = '0;
    logic        rom_shadow = 1'b0;
    logic        rom_wr_under = 1'b0;
    logic        ram_cs, rom_cs, io_cs;
    logic [5:0]  slot_cs;
    logic [15:0] io_grp_sel;
    logic [3:0]  bank_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    paged_bus_decoder uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .phi2(phi2),
        .bank_reg(bank_reg), .page_en(page_en), .rom_shadow(rom_shadow),
        .rom_wr_under(rom_wr_under), .ram_cs(ram_cs), .rom_cs(rom_cs), .io_cs(io_cs),
        .slot_cs(slot_cs), .io_grp_sel(io_grp_sel), .bank_addr(bank_addr)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] addr;
        logic        rnw;
        logic        ph;
        logic [3:0]  bank;
        logic [2:0]  pg;
        logic        shd;
        logic        wru;
        logic        e_ram;
        logic        e_rom;
        logic        e_io;
        logic [5:0]  e_slot;
        logic [3:0]  e_bank;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 16'h0123, 1'b1, 1'b1, 4'd5,  3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R3
        '{4'd3, 16'h0FFF, 1'b0, 1'b1, 4'd12, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R3
        '{4'd4, 16'h1000, 1'b1, 1'b1, 4'd5,  3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R4
        '{4'd4, 16'h1000, 1'b1, 1'b1, 4'd5,  3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd5},  // R4
        '{4'd4, 16'h2800, 1'b1, 1'b1, 4'd9,  3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R4
        '{4'd4, 16'h2800, 1'b1, 1'b1, 4'd9,  3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000010, 4'd9},  // R4
        '{4'd4, 16'h3FFF, 1'b0, 1'b1, 4'd14, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 4'd14}, // R4
        '{4'd5, 16'h4000, 1'b1, 1'b1, 4'd0,  3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R5
        '{4'd5, 16'hBFFF, 1'b0, 1'b1, 4'd7,  3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd7},  // R5
        '{4'd5, 16'h8000, 1'b1, 1'b1, 4'd8,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000001, 4'd8},  // R5
        '{4'd5, 16'h8000, 1'b1, 1'b1, 4'd13, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100000, 4'd13}, // R5
        '{4'd5, 16'hC100, 1'b1, 1'b1, 4'd11, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b001000, 4'd11}, // R5
        '{4'd5, 16'hCFFF, 1'b1, 1'b1, 4'd15, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 4'd15}, // R5
        '{4'd6, 16'hC000, 1'b1, 1'b1, 4'd9,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 4'd0},  // R6
        '{4'd6, 16'hC0F5, 1'b0, 1'b1, 4'd3,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 4'd0},  // R6
        '{4'd7, 16'hD000, 1'b1, 1'b1, 4'd6,  3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 4'd0},  // R7
        '{4'd7, 16'hFFFC, 1'b1, 1'b1, 4'd6,  3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R7
        '{4'd7, 16'hE000, 1'b0, 1'b1, 4'd6,  3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R7
        '{4'd8, 16'hE000, 1'b0, 1'b1, 4'd6,  3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000000, 4'd0},  // R8
        '{4'd8, 16'hE000, 1'b0, 1'b1, 4'd6,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 4'd0},  // R8
        '{4'd8, 16'hF000, 1'b1, 1'b1, 4'd6,  3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000000, 4'd0},  // R8
        '{4'd2, 16'h5000, 1'b1, 1'b0, 4'd6,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 4'd6},  // R2
        '{4'd2, 16'hC010, 1'b1, 1'b0, 4'd6,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 4'd0}   // R2
    };

    task automatic drive(input vec_t v);
        @(negedge clk);
        cpu_addr     = v.addr;
        cpu_rnw      = v.rnw;
        phi2         = v.ph;
        bank_reg     = v.bank;
        page_en      = v.pg;
        rom_shadow   = v.shd;
        rom_wr_under = v.wru;
    endtask

    task automatic expect_out(input int req, input string what, input vec_t v);
        logic [12:0] act, exp;
        act = {ram_cs, rom_cs, io_cs, slot_cs, bank_addr};
        exp = {v.e_ram, v.e_rom, v.e_io, v.e_slot, v.e_bank};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: {ram,rom,io,slot,bank} actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t v;
        // R1: reset held against an address that would select RAM
        cpu_addr = 16'h4000; phi2 = 1'b1; bank_reg = 4'd3;
        repeat (3) @(posedge clk);
        #1;
        v = '{4'd1, 16'h4000, 1'b1, 1'b1, 4'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 4'd0};
        expect_out(1, "reset", v);
        expect_val("R1 io_grp_sel in reset", io_grp_sel, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(posedge clk);
            #1;
            expect_out(int'(VEC[i].req), $sformatf("vector %0d", i), VEC[i]);
            // R9: never more than one select
            expect_val("R9 select count", 16'($countones({ram_cs, rom_cs, io_cs, slot_cs})) <= 16'd1 ? 16'd1 : 16'd0, 16'd1);
        end

        // R6: every register group inside the I/O page
        for (int g = 0; g < 16; g++) begin
            v = VEC[13];
            v.addr = 16'hC000 | 16'(g << 4) | 16'h0007;
            drive(v);
            @(posedge clk);
            #1;
            expect_val($sformatf("R6 io_grp_sel group %0d", g), io_grp_sel, 16'd1 << g);
        end
        // R6: group select is idle outside the I/O page
        drive(VEC[7]);
        @(posedge clk);
        #1;
        expect_val("R6 io_grp_sel outside page", io_grp_sel, 16'h0000);

        // R10: output holds until the next edge, then follows
        drive(VEC[9]);
        @(posedge clk);
        #1;
        expect_out(10, "latency first", VEC[9]);
        drive(VEC[12]);
        #1;
        expect_out(10, "latency held before edge", VEC[9]);
        @(posedge clk);
        #1;
        expect_out(10, "latency after edge", VEC[12]);

        // R1: reset asserted mid-run clears outputs
        drive(VEC[10]);
        rst = 1'b1;
        @(posedge clk);
        #1;
        v = '{4'd1, 16'h0, 1'b1, 1'b1, 4'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 4'd0};
        expect_out(1, "reset mid-run", v);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule